// File: doc/BRIEF.md
# Oscillator Tracking Controller

This block computes the control word of a digitally controlled oscillator from timing measurements, so that the divided oscillator clock locks to a reference clock in both frequency and phase. It goes through three phases in order. First it converts a measured reference period into a starting word. Next it runs a coarse loop that removes the frequency error and the phase error together. Last it runs a binary-search fine loop driven by a single lead/lag bit. All measurements are turned into control-word units by one unsigned scale factor with four fraction bits. Every new word is limited to the range the oscillator accepts.

Around the block, the measurement logic supplies a period sample, signed phase-error samples, a lead/lag bit and a watchdog flag. The oscillator latches `cw_o` whenever `cw_ld_o` pulses. A mid-cycle strobe `mid_i` marks the point where the temporary half-period correction word is replaced by the corrected full-period word. If the watchdog fires during any tracking phase, the controller drops lock and restarts from the period measurement.

Top module: `pll_trk_ctrl`

## Requirements
- R1: After reset, `cw_o` is 0, `cw_ld_o` is low, `locked_o` is low, and the controller waits for a period sample.
- R2: In the period phase, each `period_vld_i` loads clamp((period*K)>>>4) with one `cw_ld_o` pulse in the following cycle. The loaded word becomes the base word. The controller stays in the period phase if `wdog_i` is high in that cycle and moves to coarse tracking otherwise.
- R3: Coarse tracking takes two scaled error samples e1 and e2 and sets eps = e2 - e1. On the second sample it loads the correction word clamp((base>>1) + 2*eps + e1).
- R4: In the first `mid_i` strobe after the correction word, the controller loads clamp(base + eps), and that word becomes the new base.
- R5: The next error sample after the full-period word is a lock test. If its scaled magnitude is below TDCMIN (16 by default), the controller enters fine tracking with step TDCMIN. Otherwise it starts another coarse pass. The lock test loads nothing.
- R6: In fine tracking, each error strobe loads clamp(cw + step) when `lead_i` is 1 and clamp(cw - step) when `lead_i` is 0. The step then halves, but never drops below 1.
- R7: `locked_o` is high exactly while in fine tracking with step 1. Later fine decisions keep the step at 1.
- R8: `wdog_i` high in any tracking phase returns the controller to the period phase. It clears `locked_o` and loads nothing.
- R9: Every loaded word is clamped to the range 0 to 2^CW_W-1 (0 to 4095 by default).
- R10: Error strobes in the period phase, and `mid_i` strobes outside the wait for the full-period word, produce no load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_period_i | input | MEAS_W | Measured reference period, unsigned |
| period_vld_i | input | 1 | Period sample strobe |
| err_i | input | ERR_W | Signed phase-error sample |
| err_vld_i | input | 1 | Error sample strobe |
| mid_i | input | 1 | Mid-cycle strobe of the divided clock |
| lead_i | input | 1 | 1 when the divided clock leads the reference |
| wdog_i | input | 1 | Watchdog flag |
| kfac_i | input | K_W | Scale factor, unsigned, 4 fraction bits |
| cw_o | output | CW_W | Oscillator control word |
| cw_ld_o | output | 1 | One-cycle load strobe for `cw_o` |
| locked_o | output | 1 | Lock status |

## Verification
The bench targets the following corner cases:
- **Lock-test threshold.** A scaled error of exactly 16 must send the controller back to coarse tracking, while 15 must let it into fine tracking. An off-by-one compare would pass 16 through to fine tracking.
- **Negative errors with a fractional scale factor.** These check that scaling rounds toward minus infinity. A logical shift would produce huge words instead.
- **Clamping at both ends.** A correction word that goes below zero must load 0, and an oversized period must load 4095. A design that wraps would load the low bits instead.
- **Fine step sequence.** The step must go 16, 8, 4, 2, 1 and then stay at 1. A design that halved the step to zero would stop moving the word and drop lock.
- **Ignored strobes.** Watchdog aborts and stray strobes must never emit a load. The bench would see any such load as an unexpected pop from its queue.

// File: rtl/pll_trk_pkg.sv
package pll_trk_pkg;
  typedef enum logic [2:0] {
    ST_FREQ  = 3'd0,
    ST_CS1   = 3'd1,
    ST_CS2   = 3'd2,
    ST_CHALF = 3'd3,
    ST_CCHK  = 3'd4,
    ST_FINE  = 3'd5
  } trk_st_e;
endpackage

// File: rtl/pll_trk_scale.sv
// Converts a signed measurement into control-word units: (x*k) >>> KF.
module pll_trk_scale #(
  parameter int X_W   = 13,
  parameter int K_W   = 8,
  parameter int KF    = 4,
  parameter int ACC_W = 24
) (
  input  logic signed [X_W-1:0]   x_i,
  input  logic        [K_W-1:0]   k_i,
  output logic signed [ACC_W-1:0] y_o
);
  function automatic logic signed [ACC_W-1:0] scale_fn(
    input logic signed [X_W-1:0] x,
    input logic        [K_W-1:0] k
  );
    logic signed [ACC_W-1:0] xe;
    logic signed [ACC_W-1:0] ke;
    logic signed [ACC_W-1:0] prod;
    xe   = ACC_W'(x);
    ke   = ACC_W'({1'b0, k});
    prod = xe * ke;
    return prod >>> KF;
  endfunction

  assign y_o = scale_fn(x_i, k_i);
endmodule

// File: rtl/pll_trk_clamp.sv
// Limits a signed candidate word to the oscillator range.
module pll_trk_clamp #(
  parameter int ACC_W = 24,
  parameter int CW_W  = 12
) (
  input  logic signed [ACC_W-1:0] v_i,
  output logic        [CW_W-1:0]  w_o
);
  localparam logic signed [ACC_W-1:0] VMAX = ACC_W'((1 << CW_W) - 1);

  function automatic logic [CW_W-1:0] clamp_fn(input logic signed [ACC_W-1:0] v);
    if (v < 0)         return '0;
    else if (v > VMAX) return '1;
    else               return v[CW_W-1:0];
  endfunction

  assign w_o = clamp_fn(v_i);
endmodule

// File: rtl/pll_trk_coarse.sv
// Coarse-pass arithmetic: frequency error, half-period correction, full word.
module pll_trk_coarse #(
  parameter int ACC_W = 24,
  parameter int CW_W  = 12
) (
  input  logic        [CW_W-1:0]  base_i,
  input  logic signed [ACC_W-1:0] e1_i,
  input  logic signed [ACC_W-1:0] e2_i,
  input  logic signed [ACC_W-1:0] eps_hold_i,
  output logic signed [ACC_W-1:0] eps_o,
  output logic signed [ACC_W-1:0] corr_o,
  output logic signed [ACC_W-1:0] full_o
);
  logic signed [ACC_W-1:0] base_s;

  function automatic logic signed [ACC_W-1:0] corr_fn(
    input logic signed [ACC_W-1:0] base,
    input logic signed [ACC_W-1:0] eps,
    input logic signed [ACC_W-1:0] e1
  );
    return (base >>> 1) + (eps <<< 1) + e1;
  endfunction

  assign base_s = ACC_W'({1'b0, base_i});
  assign eps_o  = e2_i - e1_i;
  assign corr_o = corr_fn(base_s, eps_o, e1_i);
  assign full_o = base_s + eps_hold_i;
endmodule

// File: rtl/pll_trk_fine.sv
// Binary-search step register and the next fine-tracking candidate word.
module pll_trk_fine #(
  parameter int TDCMIN = 16,
  parameter int STEP_W = 5,
  parameter int CW_W   = 12,
  parameter int ACC_W  = 24
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    seed_i,
  input  logic                    adv_i,
  input  logic                    lead_i,
  input  logic        [CW_W-1:0]  cw_i,
  output logic        [STEP_W-1:0] step_o,
  output logic                    at_lsb_o,
  output logic signed [ACC_W-1:0] cand_o
);
  localparam logic [STEP_W-1:0] SEED = STEP_W'(TDCMIN);
  localparam logic [STEP_W-1:0] ONE  = STEP_W'(1);

  logic [STEP_W-1:0] step_q;

  function automatic logic [STEP_W-1:0] halve_fn(input logic [STEP_W-1:0] s);
    return (s > ONE) ? (s >> 1) : ONE;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      step_q <= SEED;
    else if (seed_i) step_q <= SEED;
    else if (adv_i)  step_q <= halve_fn(step_q);
  end

  logic signed [ACC_W-1:0] cw_s;
  logic signed [ACC_W-1:0] st_s;
  assign cw_s     = ACC_W'({1'b0, cw_i});
  assign st_s     = ACC_W'({1'b0, step_q});
  assign cand_o   = lead_i ? (cw_s + st_s) : (cw_s - st_s);
  assign step_o   = step_q;
  assign at_lsb_o = (step_q == ONE);
endmodule

// File: rtl/pll_trk_ctrl.sv
module pll_trk_ctrl
  import pll_trk_pkg::*;
#(
  parameter int CW_W   = 12,
  parameter int MEAS_W = 12,
  parameter int ERR_W  = 10,
  parameter int K_W    = 8,
  parameter int KF     = 4,
  parameter int TDCMIN = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [MEAS_W-1:0]       ref_period_i,
  input  logic                    period_vld_i,
  input  logic signed [ERR_W-1:0] err_i,
  input  logic                    err_vld_i,
  input  logic                    mid_i,
  input  logic                    lead_i,
  input  logic                    wdog_i,
  input  logic [K_W-1:0]          kfac_i,
  output logic [CW_W-1:0]         cw_o,
  output logic                    cw_ld_o,
  output logic                    locked_o
);
  localparam int X_W    = (MEAS_W + 1 > ERR_W) ? (MEAS_W + 1) : ERR_W;
  localparam int ACC_W  = ((X_W > CW_W) ? X_W : CW_W) + K_W + 4;
  localparam int STEP_W = $clog2(TDCMIN + 1);
  localparam logic signed [ACC_W-1:0] LIM = ACC_W'(TDCMIN);

  trk_st_e st_q, st_d;
  logic [CW_W-1:0]         cw_q, base_q, base_d;
  logic                    ld_q, ld_d;
  logic signed [ACC_W-1:0] e1_q, e1_d, eps_q, eps_d;

  // named internal events
  logic signed [X_W-1:0]   per_x, err_x;
  logic signed [ACC_W-1:0] per_s, err_s, err_mag;
  logic signed [ACC_W-1:0] eps_now, corr_w, full_w, fine_w, cand;
  logic [CW_W-1:0]         cand_cl;
  logic [STEP_W-1:0]       step_w;
  logic                    at_lsb, seed, adv, wd_abort, near_lock;

  assign per_x = X_W'({1'b0, ref_period_i});
  assign err_x = X_W'(err_i);

  pll_trk_scale #(.X_W(X_W), .K_W(K_W), .KF(KF), .ACC_W(ACC_W)) u_scale_per (
    .x_i(per_x), .k_i(kfac_i), .y_o(per_s));

  pll_trk_scale #(.X_W(X_W), .K_W(K_W), .KF(KF), .ACC_W(ACC_W)) u_scale_err (
    .x_i(err_x), .k_i(kfac_i), .y_o(err_s));

  pll_trk_coarse #(.ACC_W(ACC_W), .CW_W(CW_W)) u_coarse (
    .base_i(base_q), .e1_i(e1_q), .e2_i(err_s), .eps_hold_i(eps_q),
    .eps_o(eps_now), .corr_o(corr_w), .full_o(full_w));

  pll_trk_fine #(.TDCMIN(TDCMIN), .STEP_W(STEP_W), .CW_W(CW_W), .ACC_W(ACC_W)) u_fine (
    .clk(clk), .rst_n(rst_n), .seed_i(seed), .adv_i(adv), .lead_i(lead_i),
    .cw_i(cw_q), .step_o(step_w), .at_lsb_o(at_lsb), .cand_o(fine_w));

  pll_trk_clamp #(.ACC_W(ACC_W), .CW_W(CW_W)) u_clamp (
    .v_i(cand), .w_o(cand_cl));

  assign err_mag   = (err_s < 0) ? -err_s : err_s;
  assign near_lock = (err_mag < LIM);
  assign wd_abort  = wdog_i && (st_q != ST_FREQ);

  always_comb begin
    st_d   = st_q;
    ld_d   = 1'b0;
    cand   = ACC_W'({1'b0, cw_q});
    base_d = base_q;
    e1_d   = e1_q;
    eps_d  = eps_q;
    seed   = 1'b0;
    adv    = 1'b0;
    if (wd_abort) begin
      st_d = ST_FREQ;
    end else begin
      unique case (st_q)
        ST_FREQ: if (period_vld_i) begin
          cand   = per_s;
          ld_d   = 1'b1;
          base_d = cand_cl;
          st_d   = wdog_i ? ST_FREQ : ST_CS1;
        end
        ST_CS1: if (err_vld_i) begin
          e1_d = err_s;
          st_d = ST_CS2;
        end
        ST_CS2: if (err_vld_i) begin
          eps_d = eps_now;
          cand  = corr_w;
          ld_d  = 1'b1;
          st_d  = ST_CHALF;
        end
        ST_CHALF: if (mid_i) begin
          cand   = full_w;
          ld_d   = 1'b1;
          base_d = cand_cl;
          st_d   = ST_CCHK;
        end
        ST_CCHK: if (err_vld_i) begin
          if (near_lock) begin
            st_d = ST_FINE;
            seed = 1'b1;
          end else begin
            st_d = ST_CS1;
          end
        end
        ST_FINE: if (err_vld_i) begin
          cand = fine_w;
          ld_d = 1'b1;
          adv  = 1'b1;
        end
        default: st_d = ST_FREQ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_FREQ;
      cw_q   <= '0;
      ld_q   <= 1'b0;
      base_q <= '0;
      e1_q   <= '0;
      eps_q  <= '0;
    end else begin
      st_q   <= st_d;
      ld_q   <= ld_d;
      base_q <= base_d;
      e1_q   <= e1_d;
      eps_q  <= eps_d;
      if (ld_d) cw_q <= cand_cl;
    end
  end

  assign cw_o     = cw_q;
  assign cw_ld_o  = ld_q;
  assign locked_o = (st_q == ST_FINE) && at_lsb;
endmodule

// File: rtl/pll_trk_chk.sv
module pll_trk_chk
  import pll_trk_pkg::*;
#(
  parameter int TDCMIN = 16
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        period_vld_i,
  input logic                        err_vld_i,
  input logic                        mid_i,
  input logic                        wdog_i,
  input logic                        cw_ld_o,
  input logic                        locked_o,
  input trk_st_e                     st,
  input logic [$clog2(TDCMIN+1)-1:0] step
);
  localparam int STEP_W = $clog2(TDCMIN + 1);
  localparam logic [STEP_W-1:0] ONE = STEP_W'(1);

  p_load_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cw_ld_o |-> $past(period_vld_i || err_vld_i || mid_i));

  p_freq_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FREQ && period_vld_i && wdog_i) |=> (st == ST_FREQ && cw_ld_o));

  p_wdog_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wdog_i && st != ST_FREQ) |=> (st == ST_FREQ && !locked_o && !cw_ld_o));

  p_lock_fine_r7: assert property (@(posedge clk) disable iff (!rst_n)
    locked_o |-> (st == ST_FINE && step == ONE));

  p_step_pow2_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FINE) |-> ($countones(step) == 1));

  p_step_halve_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FINE && err_vld_i && !wdog_i) |=>
      (step == (($past(step) > ONE) ? ($past(step) >> 1) : ONE)));
endmodule

bind pll_trk_ctrl pll_trk_chk #(.TDCMIN(TDCMIN)) u_pll_trk_chk (
  .clk(clk), .rst_n(rst_n), .period_vld_i(period_vld_i), .err_vld_i(err_vld_i),
  .mid_i(mid_i), .wdog_i(wdog_i), .cw_ld_o(cw_ld_o), .locked_o(locked_o),
  .st(st_q), .step(step_w));

// File: tb/pll_trk_ctrl_bench.sv
module pll_trk_ctrl_bench;
  localparam int CW_W = 12, MEAS_W = 12, ERR_W = 10, K_W = 8;
  localparam int CWMAX = (1 << CW_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [MEAS_W-1:0] ref_period_i = '0;
  logic period_vld_i = 1'b0;
  logic signed [ERR_W-1:0] err_i = '0;
  logic err_vld_i = 1'b0, mid_i = 1'b0, lead_i = 1'b0, wdog_i = 1'b0;
  logic [K_W-1:0] kfac_i = 8'd16;
  logic [CW_W-1:0] cw_o;
  logic cw_ld_o, locked_o;

  always #2 clk = ~clk;

  pll_trk_ctrl u_pll_trk_ctrl (
    .clk(clk), .rst_n(rst_n), .ref_period_i(ref_period_i), .period_vld_i(period_vld_i),
    .err_i(err_i), .err_vld_i(err_vld_i), .mid_i(mid_i), .lead_i(lead_i),
    .wdog_i(wdog_i), .kfac_i(kfac_i), .cw_o(cw_o), .cw_ld_o(cw_ld_o), .locked_o(locked_o));

  int n_chk = 0, n_fail = 0;
  int exp_q[$];
  string req_q[$];
  int kf = 16;

  function automatic int scl(input int x, input int k);
    return (x * k) >>> 4;
  endfunction
  function automatic int clw(input int v);
    return (v < 0) ? 0 : ((v > CWMAX) ? CWMAX : v);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pops expected loads as they appear
  always @(negedge clk) begin
    if (rst_n && cw_ld_o) begin
      if (exp_q.size() == 0) check(1'b0, "R10 unexpected load", int'(cw_o), -1);
      else begin
        automatic int e = exp_q.pop_front();
        automatic string r = req_q.pop_front();
        check(int'(cw_o) == e, r, int'(cw_o), e);
      end
    end
  end

  task automatic push(input int v, input string r);
    exp_q.push_back(v);
    req_q.push_back(r);
  endtask

  task automatic drained(input string r);
    @(negedge clk);
    check(exp_q.size() == 0, r, exp_q.size(), 0);
    exp_q.delete();
    req_q.delete();
  endtask

  task automatic drv_period(input int p, input bit wd, input int exp, input string r);
    @(negedge clk);
    ref_period_i = MEAS_W'(p); period_vld_i = 1'b1; wdog_i = wd;
    push(exp, r);
    @(negedge clk);
    period_vld_i = 1'b0; wdog_i = 1'b0;
    drained(r);
  endtask

  task automatic drv_err(input int e, input bit ld, input bit has, input int exp, input string r);
    @(negedge clk);
    err_i = ERR_W'(e); err_vld_i = 1'b1; lead_i = ld;
    if (has) push(exp, r);
    @(negedge clk);
    err_vld_i = 1'b0;
    drained(r);
  endtask

  task automatic drv_mid(input bit has, input int exp, input string r);
    @(negedge clk);
    mid_i = 1'b1;
    if (has) push(exp, r);
    @(negedge clk);
    mid_i = 1'b0;
    drained(r);
  endtask

  task automatic drv_wdog();
    @(negedge clk);
    wdog_i = 1'b1;
    @(negedge clk);
    wdog_i = 1'b0;
    drained("R8");
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int w, e1, e2, eps, cw;
    repeat (3) @(negedge clk);
    check(cw_o == 0, "R1 cw", int'(cw_o), 0);
    check(!cw_ld_o, "R1 ld", int'(cw_ld_o), 0);
    check(!locked_o, "R1 lock", int'(locked_o), 0);
    rst_n = 1'b1;

    // R2: watchdog keeps controller in period phase
    drv_period(800, 1'b1, clw(scl(800, kf)), "R2 wd-hold");
    drv_err(30, 1'b0, 1'b0, 0, "R10 err in freq");
    drv_mid(1'b0, 0, "R10 mid in freq");
    w = clw(scl(1000, kf));
    drv_period(1000, 1'b0, w, "R2 advance");
    drv_mid(1'b0, 0, "R10 mid in coarse");

    // R3/R4 first coarse pass, positive errors
    e1 = scl(20, kf); e2 = scl(26, kf); eps = e2 - e1;
    drv_err(20, 1'b0, 1'b0, 0, "R3 first sample");
    drv_err(26, 1'b0, 1'b1, clw((w >>> 1) + 2 * eps + e1), "R3 corr");
    w = clw(w + eps);
    drv_mid(1'b1, w, "R4 full");
    drv_err(40, 1'b0, 1'b0, 0, "R5 too large");
    check(!locked_o, "R5 unlocked", int'(locked_o), 0);

    // second pass, negative errors
    e1 = scl(-10, kf); e2 = scl(-13, kf); eps = e2 - e1;
    drv_err(-10, 1'b0, 1'b0, 0, "R3 first sample");
    drv_err(-13, 1'b0, 1'b1, clw((w >>> 1) + 2 * eps + e1), "R3 corr neg");
    w = clw(w + eps);
    drv_mid(1'b1, w, "R4 full neg");
    drv_err(5, 1'b0, 1'b0, 0, "R5 enter fine");
    check(!locked_o, "R7 not yet", int'(locked_o), 0);

    // R6 fine search 16,8,4,2,1
    cw = w;
    cw = cw + 16; drv_err(0, 1'b1, 1'b1, cw, "R6 lead 16");
    cw = cw - 8;  drv_err(0, 1'b0, 1'b1, cw, "R6 lag 8");
    cw = cw - 4;  drv_err(0, 1'b0, 1'b1, cw, "R6 lag 4");
    check(!locked_o, "R7 step2", int'(locked_o), 0);
    cw = cw + 2;  drv_err(0, 1'b1, 1'b1, cw, "R6 lead 2");
    check(locked_o, "R7 locked", int'(locked_o), 1);
    cw = cw - 1;  drv_err(0, 1'b0, 1'b1, cw, "R6 step floor");
    cw = cw - 1;  drv_err(0, 1'b0, 1'b1, cw, "R7 hold lsb");
    check(locked_o, "R7 stays", int'(locked_o), 1);

    // R8 watchdog abort
    drv_wdog();
    check(!locked_o, "R8 unlock", int'(locked_o), 0);
    check(int'(cw_o) == cw, "R8 no load", int'(cw_o), cw);
    drv_err(50, 1'b0, 1'b0, 0, "R8 back in freq");

    // R9 clamp high
    kf = 24; kfac_i = 8'd24;
    drv_period(3000, 1'b0, clw(scl(3000, kf)), "R9 clamp high");
    drv_wdog();

    // R9 clamp low
    kf = 16; kfac_i = 8'd16;
    w = clw(scl(100, kf));
    drv_period(100, 1'b0, w, "R2 reload");
    e1 = scl(-200, kf); e2 = scl(-200, kf); eps = e2 - e1;
    drv_err(-200, 1'b0, 1'b0, 0, "R3 first sample");
    drv_err(-200, 1'b0, 1'b1, clw((w >>> 1) + 2 * eps + e1), "R9 clamp low");
    w = clw(w + eps);
    drv_mid(1'b1, w, "R4 full");
    drv_err(-300, 1'b0, 1'b0, 0, "R5 big neg");

    // fractional K, floor rounding, threshold boundary
    kf = 24; kfac_i = 8'd24;
    e1 = scl(-7, kf); e2 = scl(-9, kf); eps = e2 - e1;
    drv_err(-7, 1'b0, 1'b0, 0, "R3 first sample");
    drv_err(-9, 1'b0, 1'b1, clw((w >>> 1) + 2 * eps + e1), "R3 floor");
    w = clw(w + eps);
    drv_mid(1'b1, w, "R4 full");
    drv_err(11, 1'b0, 1'b0, 0, "R5 boundary 16");
    drv_err(-7, 1'b0, 1'b0, 0, "R3 first sample");
    drv_err(-9, 1'b0, 1'b1, clw((w >>> 1) + 2 * eps + e1), "R3 corr again");
    w = clw(w + eps);
    drv_mid(1'b1, w, "R4 full");
    drv_err(10, 1'b0, 1'b0, 0, "R5 boundary 15");
    drv_err(0, 1'b1, 1'b1, clw(w + 16), "R5 fine seeded");

    repeat (4) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule